// File: doc/BRIEF.md
# Dot-Matrix LCD Host Command and Data Decoder

This block is the host-facing front end of a dot-matrix LCD driver. The display RAM is 102 columns wide and holds 68 rows, packed eight rows per byte into 9 row banks. The host writes bytes through a single-cycle parallel strobe, and a D/C flag comes with each byte. A byte with the flag at 1 is stored in display RAM at the current pointer, and the pointer then moves to the next location by itself. A byte with the flag at 0 is a command. Commands load the configuration registers, move the pointer, or arm a two-byte configuration sequence.

A bank bit chooses how most command bytes are read. Three commands are decoded whatever the bank: the all-zero no-op, function set and set-column. Every other command works only in bank 0. A packed status byte is always visible, and a registered scan port lets the display side read RAM. Everything runs on the host clock. The control bits for the high-voltage generator and the waveform logic are held here as plain register outputs.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: A write with `wr_dc`=1 stores `wr_byte` at RAM location (bank `bank_ptr`, column `col_ptr`), and that byte is then returned on `scan_data` one cycle after its location is placed on the scan port. A write with `wr_dc`=0 never alters RAM contents.
- R2: With `addr_vertical`=0, each data write moves the column up by one. Column 101 wraps to 0, and on that wrap the bank moves up by one, with bank 8 wrapping to 0.
- R3: With `addr_vertical`=1, each data write moves the bank up by one. Bank 8 wraps to 0, and on that wrap the column moves up by one, with column 101 wrapping to 0.
- R4: Function set is command `00100 p v h`, and it is decoded in either bank. It loads `power_down`=p, `addr_vertical`=v and `bank_sel`=h.
- R5: With `bank_sel`=0, command `00001 d 0 e` sets `disp_mode`={d,e}. The four modes are 00 blank, 10 normal, 01 all segments on and 11 inverse.
- R6: With `bank_sel`=0, command `0001000 r` loads `prog_range`=r, and command `0010100 c` loads `pump_on`=c.
- R7: Command `1 xxxxxxx` loads `col_ptr`=x in either bank, but only when x ≤ 101. With `bank_sel`=0, command `0100 yyyy` loads `bank_ptr`=y, but only when y ≤ 8. A value out of range leaves the pointer unchanged.
- R8: With `bank_sel`=0, command 0x30 arms the decoder. The next command byte, whatever its code, is taken only as the configuration operand: its bit 2 goes to `data_order` and its bit 1 goes to `row_swap`. Taking that operand disarms the decoder.
- R9: The following change no register output: the no-op 0x00, any code not defined above, and any bank-0 command issued while `bank_sel`=1.
- R10: `status_byte` is laid out from MSB to LSB as BUSY (always 0), display-on (1 when `disp_mode`≠00), reset flag, MUX_CODE[2:0] and SIZE_CODE[1:0]. The reset flag is 1 from reset until the first write strobe and 0 after it.
- R11: After reset, the outputs are `power_down`=1, all other configuration bits 0, both pointers 0 and `status_byte`=0x36 with the default codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host interface clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_dc | input | 1 | 0 = command byte, 1 = display data byte |
| wr_byte | input | 8 | Byte being written |
| scan_bank | input | 4 | Display-side read bank |
| scan_col | input | 7 | Display-side read column |
| scan_data | output | 8 | Registered RAM read data |
| status_byte | output | 8 | Packed status |
| power_down | output | 1 | Power-down control bit |
| addr_vertical | output | 1 | 1 = bank-first pointer advance |
| bank_sel | output | 1 | Command bank select |
| disp_mode | output | 2 | {d,e} display mode |
| prog_range | output | 1 | Drive-voltage program range |
| pump_on | output | 1 | High-voltage generator enable |
| data_order | output | 1 | Configuration: data bit order |
| row_swap | output | 1 | Configuration: top/bottom swap |
| col_ptr | output | 7 | Current RAM column |
| bank_ptr | output | 4 | Current RAM bank |

## Verification
A wrong pointer shows up as a wrong pointer value on the edge after the write. The RAM pattern read back through the scan port then moves off its expected place, so filling the whole array in both advance orders and reading it back catches any step or wrap error. A decoder that leaks through the bank bit or through the armed state shows up at once, on the very next edge, as a changed register output. For that reason every command code is swept in bank 1, and all register outputs are compared after every byte.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef struct packed {
    logic       pd;
    logic       vert;
    logic       h;
    logic [1:0] mode;
    logic       prs;
    logic       pc;
    logic       dorder;
    logic       swap;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{pd: 1'b1, vert: 1'b0, h: 1'b0, mode: 2'b00,
                                 prs: 1'b0, pc: 1'b0, dorder: 1'b0, swap: 1'b0};

  localparam logic [4:0] OP_FUNC  = 5'b00100;
  localparam logic [4:0] OP_DISP  = 5'b00001;
  localparam logic [6:0] OP_PRS   = 7'b0001000;
  localparam logic [6:0] OP_PC    = 7'b0010100;
  localparam logic [7:0] OP_ARM   = 8'h30;
  localparam logic [3:0] OP_SETY  = 4'b0100;

  function automatic logic [7:0] pack_status(input logic disp_on, input logic res,
                                             input logic [2:0] mux, input logic [1:0] sz);
    return {1'b0, disp_on, res, mux, sz};
  endfunction

endpackage

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
  parameter int DEPTH = 918,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lcd_addr_ptr.sv
module lcd_addr_ptr #(
  parameter int COLS  = 102,
  parameter int BANKS = 9,
  localparam int CW = $clog2(COLS),
  localparam int BW = $clog2(BANKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vert,
  input  logic          adv,
  input  logic          ld_col,
  input  logic [CW-1:0] col_val,
  input  logic          ld_bank,
  input  logic [BW-1:0] bank_val,
  output logic [CW-1:0] col,
  output logic [BW-1:0] bank
);
  logic col_last, bank_last;
  logic [CW-1:0] col_inc;
  logic [BW-1:0] bank_inc;

  assign col_last  = (col == CW'(COLS - 1));
  assign bank_last = (bank == BW'(BANKS - 1));
  assign col_inc   = col_last ? '0 : col + CW'(1);
  assign bank_inc  = bank_last ? '0 : bank + BW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      col  <= '0;
      bank <= '0;
    end else if (adv) begin
      if (!vert) begin
        col <= col_inc;
        if (col_last) bank <= bank_inc;
      end else begin
        bank <= bank_inc;
        if (bank_last) col <= col_inc;
      end
    end else begin
      if (ld_col)  col  <= col_val;
      if (ld_bank) bank <= bank_val;
    end
  end

  // R2
  horiz_step_chk: assert property (@(posedge clk) disable iff (rst)
    adv && !vert && !col_last |=> (col == $past(col) + CW'(1)) && $stable(bank));

  // R3
  vert_step_chk: assert property (@(posedge clk) disable iff (rst)
    adv && vert && !bank_last |=> (bank == $past(bank) + BW'(1)) && $stable(col));

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(col) < COLS) && (int'(bank) < BANKS));
endmodule

// File: rtl/lcd_cmd_regs.sv
module lcd_cmd_regs
  import lcd_pkg::*;
#(
  parameter int COLS  = 102,
  parameter int BANKS = 9,
  localparam int CW = $clog2(COLS),
  localparam int BW = $clog2(BANKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_byte,
  output cfg_t          cfg,
  output logic          ld_col,
  output logic [CW-1:0] col_val,
  output logic          ld_bank,
  output logic [BW-1:0] bank_val
);
  logic armed;
  logic is_func, is_x, is_y, is_disp, is_prs, is_pc, is_arm;

  assign is_func = (cmd_byte[7:3] == OP_FUNC);
  assign is_x    = cmd_byte[7];
  assign is_y    = (cmd_byte[7:4] == OP_SETY);
  assign is_disp = (cmd_byte[7:3] == OP_DISP) && !cmd_byte[1];
  assign is_prs  = (cmd_byte[7:1] == OP_PRS);
  assign is_pc   = (cmd_byte[7:1] == OP_PC);
  assign is_arm  = (cmd_byte == OP_ARM);

  assign ld_col   = cmd_we && !armed && is_x && ({1'b0, cmd_byte[6:0]} < 8'(COLS));
  assign col_val  = CW'(cmd_byte[6:0]);
  assign ld_bank  = cmd_we && !armed && !cfg.h && is_y && ({1'b0, cmd_byte[3:0]} < 5'(BANKS));
  assign bank_val = BW'(cmd_byte[3:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= CFG_RESET;
      armed <= 1'b0;
    end else if (cmd_we) begin
      if (armed) begin
        armed      <= 1'b0;
        cfg.dorder <= cmd_byte[2];
        cfg.swap   <= cmd_byte[1];
      end else if (is_func) begin
        cfg.pd   <= cmd_byte[2];
        cfg.vert <= cmd_byte[1];
        cfg.h    <= cmd_byte[0];
      end else if (!cfg.h) begin
        if (is_disp)     cfg.mode <= {cmd_byte[2], cmd_byte[0]};
        else if (is_prs) cfg.prs  <= cmd_byte[0];
        else if (is_pc)  cfg.pc   <= cmd_byte[0];
        else if (is_arm) armed    <= 1'b1;
      end
    end
  end

  // R9
  bank1_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_we && !armed && cfg.h && !is_func |=> $stable(cfg));

  // R8
  operand_consume_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_we && armed |=> !armed && $stable({cfg.pd, cfg.vert, cfg.h, cfg.mode, cfg.prs, cfg.pc}));

  // R8
  operand_no_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> !ld_col && !ld_bank);
endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder
  import lcd_pkg::*;
#(
  parameter int          COLS      = 102,
  parameter int          BANKS     = 9,
  parameter logic [2:0]  MUX_CODE  = 3'd5,
  parameter logic [1:0]  SIZE_CODE = 2'd2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       wr_dc,
  input  logic [7:0]                 wr_byte,
  input  logic [$clog2(BANKS)-1:0]   scan_bank,
  input  logic [$clog2(COLS)-1:0]    scan_col,
  output logic [7:0]                 scan_data,
  output logic [7:0]                 status_byte,
  output logic                       power_down,
  output logic                       addr_vertical,
  output logic                       bank_sel,
  output logic [1:0]                 disp_mode,
  output logic                       prog_range,
  output logic                       pump_on,
  output logic                       data_order,
  output logic                       row_swap,
  output logic [$clog2(COLS)-1:0]    col_ptr,
  output logic [$clog2(BANKS)-1:0]   bank_ptr
);
  localparam int CW    = $clog2(COLS);
  localparam int BW    = $clog2(BANKS);
  localparam int DEPTH = COLS * BANKS;
  localparam int AW    = $clog2(DEPTH);

  cfg_t          cfg;
  logic          ld_col, ld_bank, data_we, res_flag;
  logic [CW-1:0] col_val;
  logic [BW-1:0] bank_val;
  logic [AW-1:0] waddr, raddr;

  assign data_we = wr_en && wr_dc;

  lcd_cmd_regs #(.COLS(COLS), .BANKS(BANKS)) u_regs (
    .clk(clk), .rst(rst), .cmd_we(wr_en && !wr_dc), .cmd_byte(wr_byte),
    .cfg(cfg), .ld_col(ld_col), .col_val(col_val), .ld_bank(ld_bank), .bank_val(bank_val)
  );

  lcd_addr_ptr #(.COLS(COLS), .BANKS(BANKS)) u_ptr (
    .clk(clk), .rst(rst), .vert(cfg.vert), .adv(data_we),
    .ld_col(ld_col), .col_val(col_val), .ld_bank(ld_bank), .bank_val(bank_val),
    .col(col_ptr), .bank(bank_ptr)
  );

  assign waddr = AW'(bank_ptr) * AW'(COLS) + AW'(col_ptr);
  assign raddr = AW'(scan_bank) * AW'(COLS) + AW'(scan_col);

  lcd_disp_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(data_we), .waddr(waddr), .wdata(wr_byte),
    .raddr(raddr), .rdata(scan_data)
  );

  always_ff @(posedge clk) begin
    if (rst)        res_flag <= 1'b1;
    else if (wr_en) res_flag <= 1'b0;
  end

  assign status_byte   = pack_status(cfg.mode != 2'b00, res_flag, MUX_CODE, SIZE_CODE);
  assign power_down    = cfg.pd;
  assign addr_vertical = cfg.vert;
  assign bank_sel      = cfg.h;
  assign disp_mode     = cfg.mode;
  assign prog_range    = cfg.prs;
  assign pump_on       = cfg.pc;
  assign data_order    = cfg.dorder;
  assign row_swap      = cfg.swap;

  // R10
  res_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !status_byte[5]);

  // R1
  cmd_keeps_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_dc && !wr_byte[7] && (wr_byte[7:4] != OP_SETY) |=> $stable(col_ptr));
endmodule

// File: tb/lcd_cmd_decoder_tb.sv
module lcd_cmd_decoder_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, wr_dc = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [3:0] scan_bank = '0;
  logic [6:0] scan_col = '0;
  logic [7:0] scan_data, status_byte;
  logic power_down, addr_vertical, bank_sel, prog_range, pump_on, data_order, row_swap;
  logic [1:0] disp_mode;
  logic [6:0] col_ptr;
  logic [3:0] bank_ptr;

  int n_chk = 0, n_fail = 0;
  logic e_pd, e_v, e_h, e_prs, e_pc, e_do, e_sw;
  logic [1:0] e_mode;
  int e_col, e_bank;

  always #10 clk = ~clk;

  lcd_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_dc(wr_dc), .wr_byte(wr_byte),
    .scan_bank(scan_bank), .scan_col(scan_col), .scan_data(scan_data),
    .status_byte(status_byte), .power_down(power_down), .addr_vertical(addr_vertical),
    .bank_sel(bank_sel), .disp_mode(disp_mode), .prog_range(prog_range), .pump_on(pump_on),
    .data_order(data_order), .row_swap(row_swap), .col_ptr(col_ptr), .bank_ptr(bank_ptr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " power_down"}, int'(power_down), int'(e_pd));
    chk({tag, " vertical"}, int'(addr_vertical), int'(e_v));
    chk({tag, " bank_sel"}, int'(bank_sel), int'(e_h));
    chk({tag, " disp_mode"}, int'(disp_mode), int'(e_mode));
    chk({tag, " prog_range"}, int'(prog_range), int'(e_prs));
    chk({tag, " pump_on"}, int'(pump_on), int'(e_pc));
    chk({tag, " data_order"}, int'(data_order), int'(e_do));
    chk({tag, " row_swap"}, int'(row_swap), int'(e_sw));
    chk({tag, " col_ptr"}, int'(col_ptr), e_col);
    chk({tag, " bank_ptr"}, int'(bank_ptr), e_bank);
  endtask

  task automatic send(input logic dc, input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_dc = dc; wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_ram(input int bank, input int col, output logic [7:0] d);
    @(negedge clk);
    scan_bank = 4'(bank); scan_col = 7'(col);
    @(negedge clk);
    d = scan_data;
  endtask

  task automatic verify_vertical(input string tag);
    logic [7:0] d;
    for (int i = 0; i < 918; i++) begin
      read_ram(i % 9, i / 9, d);
      chk(tag, int'(d), (i * 13 + 5) % 256);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    e_pd = 1; e_v = 0; e_h = 0; e_mode = 0; e_prs = 0; e_pc = 0; e_do = 0; e_sw = 0;
    e_col = 0; e_bank = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state, R10 status layout
    check_regs("R11");
    chk("R10 status after reset", int'(status_byte), 'h36);

    // R1 R2: horizontal fill of the whole array
    for (int i = 0; i < 918; i++) send(1'b1, 8'((i * 7 + 3) % 256));
    chk("R10 reset flag cleared", int'(status_byte[5]), 0);
    check_regs("R2 pointer after full horizontal wrap");
    for (int i = 0; i < 918; i++) begin
      read_ram(i / 102, i % 102, d);
      chk("R1 R2 horizontal data", int'(d), (i * 7 + 3) % 256);
    end

    // R3: vertical fill
    send(1'b0, 8'h22); e_pd = 0; e_v = 1;
    send(1'b0, 8'h80);
    send(1'b0, 8'h40);
    check_regs("R4 function set vertical");
    for (int i = 0; i < 918; i++) send(1'b1, 8'((i * 13 + 5) % 256));
    check_regs("R3 pointer after full vertical wrap");
    verify_vertical("R3 vertical data");

    // R4: function set sweep, including from bank 1
    for (int v = 0; v < 8; v++) begin
      send(1'b0, 8'h20 | 8'(v));
      e_pd = v[2]; e_v = v[1]; e_h = v[0];
      check_regs("R4 function set");
    end
    send(1'b0, 8'h20); e_pd = 0; e_v = 0; e_h = 0;

    // R5: display modes and display-on status bit
    for (int m = 0; m < 4; m++) begin
      send(1'b0, 8'h08 | 8'(m[1] << 2) | 8'(m[0]));
      e_mode = 2'(m);
      check_regs("R5 display control");
      chk("R10 display-on bit", int'(status_byte[6]), (m != 0) ? 1 : 0);
    end
    send(1'b0, 8'h0A);
    check_regs("R9 display code with bit1 set");

    // R6
    send(1'b0, 8'h11); e_prs = 1; check_regs("R6 range set");
    send(1'b0, 8'h10); e_prs = 0; check_regs("R6 range clear");
    send(1'b0, 8'h29); e_pc = 1; check_regs("R6 pump on");

    // R7: column and bank loads, full code sweep
    for (int x = 0; x < 128; x++) begin
      send(1'b0, 8'h80 | 8'(x));
      if (x < 102) e_col = x;
      check_regs("R7 set column");
    end
    for (int y = 0; y < 16; y++) begin
      send(1'b0, 8'h40 | 8'(y));
      if (y < 9) e_bank = y;
      check_regs("R7 set bank");
    end

    // R8: double-byte configuration
    send(1'b0, 8'h30); check_regs("R8 arm");
    send(1'b0, 8'h26); e_do = 1; e_sw = 1; check_regs("R8 operand looks like function set");
    send(1'b0, 8'h30);
    send(1'b0, 8'hC0); e_do = 0; e_sw = 0; check_regs("R8 operand looks like set column");
    send(1'b0, 8'h30);
    send(1'b0, 8'h04); e_do = 1; check_regs("R8 data order only");

    // R9: every non-function-set code in bank 1 ignored
    send(1'b0, 8'h21); e_h = 1; check_regs("R4 enter bank 1");
    for (int b = 1; b < 128; b++) begin
      if (b >= 'h20 && b <= 'h27) continue;
      send(1'b0, 8'(b));
      check_regs("R9 bank 1 ignored");
    end
    send(1'b0, 8'h20); e_h = 0;
    send(1'b0, 8'h00); check_regs("R9 no-op");

    // R1: commands never touched RAM
    verify_vertical("R1 RAM after command traffic");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule